// File: doc/BRIEF.md
# ADC Sample Output Formatter with Parallel and Double-Data-Rate Packing

This block sits between the digital back end of a 14-bit pipelined converter and the output pads. Each clock it accepts one raw sample, which arrives in straight offset binary, together with two overload flags that mark a sample beyond the positive or negative full scale. It clamps overloaded samples to full-scale codes and recodes the word as offset binary or twos complement. It then presents the result either on a 14-bit single-data-rate bus or on seven double-data-rate lanes, each carrying two bits per clock.

The output coding and the bus style come from two 2-bit register fields. Each field can defer to a 2-bit strap code that a board-level control pin decodes to. A forwarded clock goes with the data. An output-enable term combines a register disable bit with an external enable pin. While it is low, the data bus, the lanes and the forwarded clock are held low and `out_en_o` tells the pad ring to float them. The over-range flag is not affected by the enable.

The sample, its over-range flag and the bus-style choice travel together through `PIPE_STAGES` register stages. The flag and the bus style therefore always describe the word that is on the outputs. The coding choice is applied as the sample enters the first stage.

Top module: `adc_out_fmt`

## Requirements
- R1: In offset-binary mode the output word equals the raw input sample. In twos-complement mode it is the signed value (raw − 8192) in 14-bit twos complement, which is the raw word with bit 13 inverted.
- R2: A sample flagged as a positive overload is output as 0x3FFF in offset binary and as 0x1FFF in twos complement. If both overload flags are set, the positive clamp wins.
- R3: A sample flagged as a negative overload, with the positive flag clear, is output as 0x0000 in offset binary and as 0x2000 in twos complement.
- R4: `ovr_o` is high exactly for the output words whose input had either overload flag set. It has the same latency as the data: an input captured at clock edge N appears after edge N+1 when PIPE_STAGES = 2.
- R5: Format field `fmt_fld_i` selects the coding: 2'b10 gives twos complement, 2'b11 gives offset binary, and 2'b00 or 2'b01 take the coding from the strap code.
- R6: Interface field `link_fld_i` selects the bus: 2'b01 gives double data rate, 2'b11 gives parallel, and 2'b00 or 2'b10 take the bus from the strap code.
- R7: Strap code `strap_i` decodes as 2'b00 = twos complement with double data rate, 2'b01 = twos complement with parallel, 2'b10 = offset binary with parallel, 2'b11 = offset binary with double data rate.
- R8: In parallel mode with outputs enabled, `par_data_o` carries the whole word, all lanes are 0, and `fclk_o` is the inverse of `clk`, so its rising edge falls mid-cycle in the data window.
- R9: In double-data-rate mode with outputs enabled, lane k carries word bit 2k while `fclk_o` is low and bit 2k+1 while `fclk_o` is high, and `par_data_o` is 0.
- R10: `out_en_o` = `oe_pin_i` AND NOT `obuf_off_i`, with no delay. While it is low, `par_data_o`, every lane and `fclk_o` are 0, and `ovr_o` is unaffected.
- R11: While `rst_n` is low, all pipeline stages clear: `par_data_o`, the lanes and `ovr_o` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_i | input | 14 | Raw sample, offset binary |
| ovr_pos_i | input | 1 | Sample exceeds positive full scale |
| ovr_neg_i | input | 1 | Sample exceeds negative full scale |
| fmt_fld_i | input | 2 | Output coding field |
| link_fld_i | input | 2 | Output bus style field |
| strap_i | input | 2 | Decoded strap code |
| obuf_off_i | input | 1 | Register bit that disables the output drivers |
| oe_pin_i | input | 1 | External output enable pin, active high |
| par_data_o | output | 14 | Parallel single-data-rate word |
| ddr_lane_o | output | 7 | Double-data-rate lanes, two bits per clock each |
| fclk_o | output | 1 | Forwarded output clock |
| ovr_o | output | 1 | Over-range flag aligned with the output word |
| out_en_o | output | 1 | Drive enable for the data and clock pads |

## Verification
The only state in the block is the pipeline of word, flag and bus-style bits.

- A stage loaded with the wrong content appears on the pins exactly PIPE_STAGES edges after the sample that caused it.
- A wrong over-range bit shows as `ovr_o` disagreeing with the clamp code on the same word.
- A wrong bus-style bit moves the word from one bus to the other. The parallel bus then reads 0 while the lanes toggle, or the reverse.

Both lane phases are sampled in every clock, so a swapped even/odd pairing is seen within the first word that has differing neighbouring bits.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

   // Output coding field; both low codes defer to the strap
   typedef enum logic [1:0] {
      FMTF_STRAP   = 2'b00,
      FMTF_STRAP_B = 2'b01,
      FMTF_TWOS    = 2'b10,
      FMTF_OFFS    = 2'b11
   } fmt_field_e;

   // Bus style field; 00 and 10 defer to the strap
   typedef enum logic [1:0] {
      LNKF_STRAP   = 2'b00,
      LNKF_DDR     = 2'b01,
      LNKF_STRAP_B = 2'b10,
      LNKF_PAR     = 2'b11
   } link_field_e;

   // Decoded strap code: {coding, bus style}
   typedef enum logic [1:0] {
      STRAP_TWOS_DDR = 2'b00,
      STRAP_TWOS_PAR = 2'b01,
      STRAP_OFFS_PAR = 2'b10,
      STRAP_OFFS_DDR = 2'b11
   } strap_e;

   typedef struct packed {
      logic twos;   // 1: twos complement, 0: offset binary
      logic ddr;    // 1: double data rate, 0: parallel
   } out_mode_t;

endpackage

// File: rtl/adc_fmt_mode_sel.sv
module adc_fmt_mode_sel
   import adc_fmt_pkg::*;
(
   input  logic [1:0] fmt_fld_i,
   input  logic [1:0] link_fld_i,
   input  logic [1:0] strap_i,
   output out_mode_t  mode_o
);

   out_mode_t strap_mode;

   // Strap decode
   always_comb begin
      strap_mode = '{twos: 1'b0, ddr: 1'b0};
      case (strap_e'(strap_i))
         STRAP_TWOS_DDR: strap_mode = '{twos: 1'b1, ddr: 1'b1};
         STRAP_TWOS_PAR: strap_mode = '{twos: 1'b1, ddr: 1'b0};
         STRAP_OFFS_PAR: strap_mode = '{twos: 1'b0, ddr: 1'b0};
         default:        strap_mode = '{twos: 1'b0, ddr: 1'b1};
      endcase
   end

   // Register fields override the strap where they force a choice
   always_comb begin
      case (fmt_field_e'(fmt_fld_i))
         FMTF_TWOS: mode_o.twos = 1'b1;
         FMTF_OFFS: mode_o.twos = 1'b0;
         default:   mode_o.twos = strap_mode.twos;
      endcase
      case (link_field_e'(link_fld_i))
         LNKF_DDR: mode_o.ddr = 1'b1;
         LNKF_PAR: mode_o.ddr = 1'b0;
         default:  mode_o.ddr = strap_mode.ddr;
      endcase
   end

endmodule

// File: rtl/adc_fmt_encode.sv
module adc_fmt_encode #(
   parameter int SMP_W = 14
) (
   input  logic [SMP_W-1:0] raw_i,
   input  logic             pos_i,
   input  logic             neg_i,
   input  logic             twos_i,
   output logic [SMP_W-1:0] code_o
);

   localparam logic [SMP_W-1:0] FS_HI    = '1;
   localparam logic [SMP_W-1:0] FS_LO    = '0;
   localparam logic [SMP_W-1:0] MSB_FLIP = {1'b1, {(SMP_W-1){1'b0}}};

   logic [SMP_W-1:0] clamped_ob;

   // Clamp in offset binary first, so one clamp serves both codings
   always_comb begin
      if (pos_i)      clamped_ob = FS_HI;
      else if (neg_i) clamped_ob = FS_LO;
      else            clamped_ob = raw_i;
   end

   assign code_o = twos_i ? (clamped_ob ^ MSB_FLIP) : clamped_ob;

endmodule

// File: rtl/adc_fmt_pipe.sv
module adc_fmt_pipe #(
   parameter int W     = 16,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] first_o,
   output logic [W-1:0] last_o
);

   logic [DEPTH-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
      end
   end

   assign first_o = stg[0];
   assign last_o  = stg[DEPTH-1];

endmodule

// File: rtl/adc_fmt_ddr_pack.sv
module adc_fmt_ddr_pack #(
   parameter int SMP_W = 14,
   localparam int LANES = SMP_W / 2
) (
   input  logic             phase_i,   // 1: even-bit half, 0: odd-bit half
   input  logic             en_i,
   input  logic [SMP_W-1:0] word_i,
   output logic [LANES-1:0] lane_o
);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign lane_o[k] = en_i & (phase_i ? word_i[2*k] : word_i[2*k+1]);
   end

endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt
   import adc_fmt_pkg::*;
#(
   parameter int SMP_W       = 14,
   parameter int PIPE_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SMP_W-1:0]   smp_i,
   input  logic               ovr_pos_i,
   input  logic               ovr_neg_i,
   input  logic [1:0]         fmt_fld_i,
   input  logic [1:0]         link_fld_i,
   input  logic [1:0]         strap_i,
   input  logic               obuf_off_i,
   input  logic               oe_pin_i,
   output logic [SMP_W-1:0]   par_data_o,
   output logic [SMP_W/2-1:0] ddr_lane_o,
   output logic               fclk_o,
   output logic               ovr_o,
   output logic               out_en_o
);

   localparam int LANES  = SMP_W / 2;
   localparam int PIPE_W = SMP_W + 2;   // {ddr, ovr, word}

   localparam logic [SMP_W-1:0] OB_HI = '1;
   localparam logic [SMP_W-1:0] OB_LO = '0;
   localparam logic [SMP_W-1:0] TC_HI = {1'b0, {(SMP_W-1){1'b1}}};
   localparam logic [SMP_W-1:0] TC_LO = {1'b1, {(SMP_W-1){1'b0}}};

   if (SMP_W < 2 || (SMP_W % 2) != 0) begin : g_bad_width
      $error("SMP_W must be even and at least 2");
   end
   if (PIPE_STAGES < 1) begin : g_bad_depth
      $error("PIPE_STAGES must be at least 1");
   end

   out_mode_t        mode;
   logic [SMP_W-1:0] enc_word;
   logic [PIPE_W-1:0] pipe_in, pipe_first, pipe_last;
   logic [SMP_W-1:0] q_word;
   logic             q_ovr, q_ddr;
   logic [SMP_W-1:0] s1_word;
   logic             s1_ovr, s1_ddr;
   logic [LANES-1:0] lanes;

   adc_fmt_mode_sel u_mode (
      .fmt_fld_i  (fmt_fld_i),
      .link_fld_i (link_fld_i),
      .strap_i    (strap_i),
      .mode_o     (mode)
   );

   adc_fmt_encode #(.SMP_W(SMP_W)) u_enc (
      .raw_i  (smp_i),
      .pos_i  (ovr_pos_i),
      .neg_i  (ovr_neg_i),
      .twos_i (mode.twos),
      .code_o (enc_word)
   );

   assign pipe_in = {mode.ddr, (ovr_pos_i | ovr_neg_i), enc_word};

   adc_fmt_pipe #(.W(PIPE_W), .DEPTH(PIPE_STAGES)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_i     (pipe_in),
      .first_o (pipe_first),
      .last_o  (pipe_last)
   );

   assign {q_ddr, q_ovr, q_word}    = pipe_last;
   assign {s1_ddr, s1_ovr, s1_word} = pipe_first;

   assign out_en_o = oe_pin_i & ~obuf_off_i;

   adc_fmt_ddr_pack #(.SMP_W(SMP_W)) u_ddr (
      .phase_i (clk),
      .en_i    (out_en_o & q_ddr),
      .word_i  (q_word),
      .lane_o  (lanes)
   );

   assign ddr_lane_o = lanes;
   assign par_data_o = (out_en_o & ~q_ddr) ? q_word : '0;
   assign fclk_o     = out_en_o & ~clk;
   assign ovr_o      = q_ovr;

   // Positive clamp lands in the first stage with the coding in force
   assert_pos_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ovr_pos_i)) |->
         (s1_word == ($past(mode.twos) ? TC_HI : OB_HI)));

   // Negative clamp when the positive flag is clear
   assert_neg_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(ovr_neg_i) && !$past(ovr_pos_i)) |->
         (s1_word == ($past(mode.twos) ? TC_LO : OB_LO)));

   // Flag enters the pipeline with its own sample
   assert_ovr_tracks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (s1_ovr == $past(ovr_pos_i | ovr_neg_i)));

   // A flagged word on the parallel bus is always one of the clamp codes
   assert_ovr_fullscale_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_o && out_en_o && !q_ddr) |->
         (par_data_o == OB_HI || par_data_o == OB_LO ||
          par_data_o == TC_HI || par_data_o == TC_LO));

   // Forcing double data rate in the field wins over any strap
   assert_link_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(link_fld_i) == 2'b01) |-> s1_ddr);

   // Disabled drivers leave the parallel bus quiet
   assert_outen_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en_o |-> (par_data_o == '0));

endmodule

// File: tb/adc_out_fmt_bench.sv
`timescale 1ns/1ps
module adc_out_fmt_bench;

   localparam real CLK_PER = 5.0;   // 200 MHz
   localparam int  W       = 14;
   localparam int  NL      = W / 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [W-1:0]  smp = '0;
   logic          pos = 1'b0, neg = 1'b0;
   logic [1:0]    fmt = 2'b11, link = 2'b11, strap = 2'b10;
   logic          obuf_off = 1'b0, oe_pin = 1'b1;
   logic [W-1:0]  par;
   logic [NL-1:0] lanes;
   logic          fclk, ovr, oen;

   int n_chk = 0;
   int n_fail = 0;
   string tag = "R1";

   typedef struct { logic [W-1:0] word; logic ovr; logic ddr; } exp_t;
   exp_t q[$];

   always #(CLK_PER/2) clk = ~clk;

   adc_out_fmt u_adc_out_fmt (
      .clk(clk), .rst_n(rst_n), .smp_i(smp), .ovr_pos_i(pos), .ovr_neg_i(neg),
      .fmt_fld_i(fmt), .link_fld_i(link), .strap_i(strap),
      .obuf_off_i(obuf_off), .oe_pin_i(oe_pin),
      .par_data_o(par), .ddr_lane_o(lanes), .fclk_o(fclk), .ovr_o(ovr),
      .out_en_o(oen)
   );

   task automatic chk(string t, string what, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", t, what, got, exp);
      end
   endtask

   function automatic logic model_twos(logic [1:0] f, logic [1:0] s);
      if (f == 2'b10) return 1'b1;
      if (f == 2'b11) return 1'b0;
      return (s == 2'b00 || s == 2'b01);
   endfunction

   function automatic logic model_ddr(logic [1:0] l, logic [1:0] s);
      if (l == 2'b01) return 1'b1;
      if (l == 2'b11) return 1'b0;
      return (s == 2'b00 || s == 2'b11);
   endfunction

   function automatic logic [W-1:0] model_word(logic [W-1:0] r, logic p, logic n, logic tc);
      int v;
      if (tc) begin
         if (p)      v = 8191;
         else if (n) v = -8192;
         else        v = int'(r) - 8192;
         return v[W-1:0];
      end
      if (p) return 14'h3FFF;
      if (n) return 14'h0000;
      return r;
   endfunction

   function automatic exp_t model_now();
      exp_t e;
      e.word = model_word(smp, pos, neg, model_twos(fmt, strap));
      e.ovr  = pos | neg;
      e.ddr  = model_ddr(link, strap);
      return e;
   endfunction

   // One clock: check both halves, then apply the next input
   task automatic cyc(logic [W-1:0] s, logic p, logic n, logic [1:0] f,
                      logic [1:0] l, logic [1:0] st, logic ob, logic oe);
      exp_t e;
      logic en;
      @(posedge clk);
      #1;
      e  = q.pop_front();
      en = oe_pin & ~obuf_off;
      chk("R10", "out_en", 32'(oen), 32'(en));
      chk(tag, "par_data", 32'(par), 32'((en && !e.ddr) ? e.word : '0));
      chk("R4", "ovr", 32'(ovr), 32'(e.ovr));
      chk(e.ddr ? "R9" : "R8", "fclk high-clk half", 32'(fclk), 32'(1'b0));
      for (int k = 0; k < NL; k++)
         chk(e.ddr ? "R9" : "R8", "lane even half", 32'(lanes[k]),
             32'(en && e.ddr ? e.word[2*k] : 1'b0));
      #2;
      chk(e.ddr ? "R9" : "R8", "fclk low-clk half", 32'(fclk), 32'(en));
      for (int k = 0; k < NL; k++)
         chk(e.ddr ? "R9" : "R8", "lane odd half", 32'(lanes[k]),
             32'(en && e.ddr ? e.word[2*k+1] : 1'b0));
      #1;
      smp = s; pos = p; neg = n; fmt = f; link = l; strap = st;
      obuf_off = ob; oe_pin = oe;
      q.push_back(model_now());
   endtask

   function automatic logic [W-1:0] rnd();
      return W'($urandom);
   endfunction

   initial begin
      #(CLK_PER * 30000);
      n_fail++;
      $display("FAIL watchdog: got hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R11: reset state
      repeat (3) @(posedge clk);
      #1;
      chk("R11", "par in reset", 32'(par), 32'(0));
      chk("R11", "lanes in reset", 32'(lanes), 32'(0));
      chk("R11", "ovr in reset", 32'(ovr), 32'(0));
      #1.5;
      chk("R11", "lanes in reset low half", 32'(lanes), 32'(0));
      rst_n = 1'b1;
      q.push_back('{word: '0, ovr: 1'b0, ddr: 1'b0});
      q.push_back(model_now());

      // R1: both codings, parallel bus
      tag = "R1";
      for (int i = 0; i < 24; i++)
         cyc(rnd(), 0, 0, (i < 12) ? 2'b11 : 2'b10, 2'b11, 2'b10, 0, 1);
      cyc(14'h2000, 0, 0, 2'b10, 2'b11, 2'b10, 0, 1);
      cyc(14'h1FFF, 0, 0, 2'b10, 2'b11, 2'b10, 0, 1);

      // R2 and R3: clamps in both codings, both flags together
      tag = "R2";
      for (int i = 0; i < 8; i++)
         cyc(rnd(), 1, i[0], i[1] ? 2'b10 : 2'b11, 2'b11, 2'b01, 0, 1);
      tag = "R3";
      for (int i = 0; i < 8; i++)
         cyc(rnd(), 0, 1, i[0] ? 2'b10 : 2'b11, 2'b11, 2'b01, 0, 1);

      // R4: flag pattern against clean samples
      tag = "R4";
      for (int i = 0; i < 20; i++)
         cyc(rnd(), (i % 5) == 1, (i % 3) == 2, 2'(i % 4), 2'b11, 2'b10, 0, 1);

      // R5: coding field deferring to each strap code
      tag = "R5";
      for (int f = 0; f < 4; f++)
         for (int s = 0; s < 4; s++)
            cyc(rnd(), 0, 0, 2'(f), 2'b11, 2'(s), 0, 1);

      // R6: bus field against each strap code
      tag = "R6";
      for (int l = 0; l < 4; l++)
         for (int s = 0; s < 4; s++)
            cyc(rnd(), 0, 0, 2'b11, 2'(l), 2'(s), 0, 1);

      // R7: strap alone selects both choices
      tag = "R7";
      for (int r = 0; r < 3; r++)
         for (int s = 0; s < 4; s++)
            cyc(rnd(), r == 2, 0, 2'b00, 2'b00, 2'(s), 0, 1);

      // R9: double-data-rate bit pairing
      tag = "R9";
      cyc(14'h1555, 0, 0, 2'b11, 2'b01, 2'b10, 0, 1);
      cyc(14'h2AAA, 0, 0, 2'b11, 2'b01, 2'b10, 0, 1);
      for (int i = 0; i < 20; i++)
         cyc(rnd(), i == 7, i == 9, 2'(i % 4), 2'b01, 2'b10, 0, 1);

      // R8: parallel mode with strap fallback
      tag = "R8";
      for (int i = 0; i < 12; i++)
         cyc(rnd(), 0, 0, 2'b11, 2'b10, 2'b01, 0, 1);

      // R10: enable pin and disable bit in every combination, both buses
      tag = "R10";
      for (int i = 0; i < 32; i++)
         cyc(rnd(), i == 5, 0, 2'b11, i[3] ? 2'b01 : 2'b11, 2'b10, i[0], i[1]);

      // Mixed traffic
      tag = "R1";
      for (int i = 0; i < 150; i++) begin
         logic [31:0] r = $urandom;
         cyc(rnd(), r[0] & r[1], r[2] & r[3], r[5:4], r[7:6], r[9:8], r[10] & r[11], ~(r[12] & r[13]));
      end
      cyc(rnd(), 0, 0, 2'b11, 2'b11, 2'b10, 0, 1);
      cyc(rnd(), 0, 0, 2'b11, 2'b11, 2'b10, 0, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule